// File: doc/BRIEF.md
# Cycle-Reconfigurable 8-bit Datapath

This block is a single-cycle byte datapath whose function is chosen anew on every clock edge. Eight stored 16-bit control words sit in a small configuration store. A 3-bit sequencer address driven from outside picks the word in force for the cycle. That word selects:

- the ALU operation and its two operands, taken from two accumulators and two data registers;
- a shift or nibble-swap stage;
- an optional static mask;
- how each accumulator is updated;
- whether the result is pushed into an output FIFO.

With these settings a small outside sequencer can build counters, timers, PWM compares, CRC steps or shifters, all from one datapath.

A host port reaches every register by address. Through the same port the host loads the configuration store, pushes bytes into either four-deep FIFO and pops bytes from it. Registered compare flags, a carry/borrow flag, a shift-out flag and the FIFO status flags are presented as outputs. The host can direct which value a FIFO feeds to its accumulator.

There is no operating state machine. The control word replaces it, and word 0 should be left as the idle word: all zero, which means pass A0 with nothing written back.

Top module: `reconf_datapath`

## Requirements
- R1: The ALU code in control bits [2:0] selects 0=pass operand A, 1=A+1, 2=A-1, 3=A+B, 4=A-B, 5=A AND B, 6=A OR B, 7=A XOR B, all modulo 256. `alu_result` shows the value written back on the clock edge where the word was in force.
- R2: Control bits [4:3] pick operand A and bits [6:5] pick operand B, each coded 0=A0, 1=A1, 2=D0, 3=D1.
- R3: `carry_out` is registered with the result. It is the carry out of bit 7 for add, 1 when A<B (unsigned) for subtract, and 0 for every other operation.
- R4: Control bits [8:7] set the shift stage:
  - 0 passes the value through;
  - 1 shifts left, fills with zero and gives old bit 7 on `shift_out`;
  - 2 shifts right, fills with zero and gives old bit 0 on `shift_out`;
  - 3 swaps the two nibbles.

  `shift_out` is 0 for codes 0 and 3.
- R5: When control bit 14 is set, the shifted value is ANDed with the mask register (host address 6, reset value 0xFF). When bit 14 is clear, the mask register has no effect.
- R6: Control bits [10:9] update A0 and bits [12:11] update A1, with codes 0=hold, 1=result, 2=D0 (for A1: D1), 3=head of F0 (for A1: F1). Code 3 pops that FIFO.
- R7: When control bit 13 is set, the result is pushed into F1.
- R8: The word in force is the stored word addressed by `seq_addr` during that cycle. The host writes word w at address 0x10+2w (bits 7:0) and 0x11+2w (bits 15:8), and reads it back at the same addresses. All words reset to zero.
- R9: The host reads and writes A0, A1, D0, D1 and the mask register at addresses 0, 1, 2, 3 and 6. A host write takes priority over a same-cycle datapath update of the same accumulator.
- R10: F0 and F1 are four-byte first-in first-out queues. A host write to address 4 or 5 pushes to F0 or F1. With `host_rd` at address 4 or 5, `host_rdata` shows the head, which is popped on that edge. Full and empty status are outputs.
- R11: A push into a full FIFO is dropped and sets that FIFO's sticky overflow flag.
- R12: A pop from an empty FIFO yields 0x00 and sets that FIFO's sticky underflow flag. This applies to host pops and to accumulator loads alike.
- R13: The compare flags are registered from the register values before each edge. They are A0==D0, A0<D0, A1==D1 and A1<D1 (unsigned), plus A0==0.
- R14: After reset the registers are 0, the mask is 0xFF, the FIFOs are empty, every sticky flag is clear, and `alu_result`, `carry_out` and `shift_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_addr | input | 3 | Selects the control word for this cycle |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops a FIFO address) |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| alu_result | output | 8 | Registered datapath result |
| carry_out | output | 1 | Registered carry/borrow |
| shift_out | output | 1 | Registered bit shifted out |
| cmp_eq0 | output | 1 | A0 equals D0 |
| cmp_lt0 | output | 1 | A0 below D0 |
| cmp_eq1 | output | 1 | A1 equals D1 |
| cmp_lt1 | output | 1 | A1 below D1 |
| a0_zero | output | 1 | A0 is zero |
| f0_full | output | 1 | F0 full |
| f0_empty | output | 1 | F0 empty |
| f1_full | output | 1 | F1 full |
| f1_empty | output | 1 | F1 empty |
| f0_overflow | output | 1 | Sticky F0 overflow |
| f0_underflow | output | 1 | Sticky F0 underflow |
| f1_overflow | output | 1 | Sticky F1 overflow |
| f1_underflow | output | 1 | Sticky F1 underflow |

## Verification
The ALU is swept over all eight operations with operand pairs drawn from 0, 1, 0x7F, 0x80, 0xFF and two irregular bytes. These pairs separate carry from no carry, borrow from no borrow, and wrap at both ends. The shift stage is driven with all 256 byte values in each of its four modes, which exposes any wrong fill bit or wrong shift-out bit. Every pairing of the operand-source fields is tried with distinct powers of two in the four registers, so any misrouted source yields a unique wrong sum. The compare flags are swept over equal, lesser and greater pairs. Write-back codes, FIFO ordering, overflow and underflow, mask on and off, host-write priority and per-cycle word selection each get a directed sequence.

// File: rtl/dp_pkg.sv
package dp_pkg;

    typedef enum logic [2:0] {
        FN_PASS = 3'd0,
        FN_INC  = 3'd1,
        FN_DEC  = 3'd2,
        FN_ADD  = 3'd3,
        FN_SUB  = 3'd4,
        FN_AND  = 3'd5,
        FN_OR   = 3'd6,
        FN_XOR  = 3'd7
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRC_A0 = 2'd0,
        SRC_A1 = 2'd1,
        SRC_D0 = 2'd2,
        SRC_D1 = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_SWAP  = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        WB_HOLD = 2'd0,
        WB_ALU  = 2'd1,
        WB_DATA = 2'd2,
        WB_FIFO = 2'd3
    } wb_e;

    // Active part of a control word (bit 15 is stored but carries no function)
    typedef struct packed {
        logic    mask_en;   // 14
        logic    push_f1;   // 13
        wb_e     a1_wb;     // 12:11
        wb_e     a0_wb;     // 10:9
        shift_e  shift;     // 8:7
        src_e    src_b;     // 6:5
        src_e    src_a;     // 4:3
        alu_fn_e fn;        // 2:0
    } ctl_t;

    localparam int CTL_W    = $bits(ctl_t);
    localparam int CW_BITS  = 16;
    localparam int HADDR_W  = 5;

    localparam logic [HADDR_W-1:0] HA_A0   = 5'h00;
    localparam logic [HADDR_W-1:0] HA_A1   = 5'h01;
    localparam logic [HADDR_W-1:0] HA_D0   = 5'h02;
    localparam logic [HADDR_W-1:0] HA_D1   = 5'h03;
    localparam logic [HADDR_W-1:0] HA_F0   = 5'h04;
    localparam logic [HADDR_W-1:0] HA_F1   = 5'h05;
    localparam logic [HADDR_W-1:0] HA_MASK = 5'h06;

endpackage

// File: rtl/dp_fifo.sv
module dp_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          overflow_o,
    output logic          underflow_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (count == FULL_CNT);
    assign empty_o = (count == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = empty_o ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data_i;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow_o  <= 1'b0;
            underflow_o <= 1'b0;
        end else begin
            if (push_i && full_o)  overflow_o  <= 1'b1;
            if (pop_i && empty_o)  underflow_o <= 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);  // R11
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (full_o && $stable(wr_ptr)));  // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);  // R11
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);  // R12
    AST_EMPTY_POP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o) |=> (underflow_o && $stable(rd_ptr)));  // R12
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));  // R10

endmodule

// File: rtl/dp_cfg_store.sv
module dp_cfg_store
    import dp_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [$clog2(WORDS)-1:0] wr_idx_i,
    input  logic                     wr_hi_i,
    input  logic [DW-1:0]            wr_data_i,
    input  logic [$clog2(WORDS)-1:0] seq_idx_i,
    output ctl_t                     ctl_o,
    input  logic [$clog2(WORDS)-1:0] hrd_idx_i,
    input  logic                     hrd_hi_i,
    output logic [DW-1:0]            hrd_data_o
);

    localparam int BYTES = CW_BITS / DW;

    logic [CW_BITS-1:0] mem [WORDS];
    logic [CW_BITS-1:0] seq_word;
    logic [CW_BITS-1:0] host_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en_i) begin
            if (wr_hi_i) mem[wr_idx_i][CW_BITS-1 -: DW] <= wr_data_i;
            else         mem[wr_idx_i][DW-1:0]         <= wr_data_i;
        end
    end

    assign seq_word   = mem[seq_idx_i];
    assign ctl_o      = ctl_t'(seq_word[CTL_W-1:0]);
    assign host_word  = mem[hrd_idx_i];
    assign hrd_data_o = hrd_hi_i ? host_word[CW_BITS-1 -: DW] : host_word[DW-1:0];

    initial begin
        assert (BYTES == 2);  // R8
    end

    AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_hi_i) |=> (mem[$past(wr_idx_i)][DW-1:0] == $past(wr_data_i)));  // R8

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_fn_e       fn_i,
    input  logic [DW-1:0] op_a_i,
    input  logic [DW-1:0] op_b_i,
    input  shift_e        shift_i,
    input  logic          mask_en_i,
    input  logic [DW-1:0] mask_i,
    output logic [DW-1:0] result_o,
    output logic          carry_o,
    output logic          shout_o
);

    localparam int HALF = DW / 2;

    logic [DW:0]   wide;
    logic [DW-1:0] alu_val;
    logic [DW-1:0] sh_val;

    always_comb begin
        wide    = '0;
        carry_o = 1'b0;
        unique case (fn_i)
            FN_PASS: alu_val = op_a_i;
            FN_INC:  alu_val = op_a_i + 1'b1;
            FN_DEC:  alu_val = op_a_i - 1'b1;
            FN_ADD: begin
                wide    = {1'b0, op_a_i} + {1'b0, op_b_i};
                alu_val = wide[DW-1:0];
                carry_o = wide[DW];
            end
            FN_SUB: begin
                wide    = {1'b0, op_a_i} - {1'b0, op_b_i};
                alu_val = wide[DW-1:0];
                carry_o = wide[DW];
            end
            FN_AND:  alu_val = op_a_i & op_b_i;
            FN_OR:   alu_val = op_a_i | op_b_i;
            FN_XOR:  alu_val = op_a_i ^ op_b_i;
            default: alu_val = op_a_i;
        endcase
    end

    always_comb begin
        shout_o = 1'b0;
        unique case (shift_i)
            SH_NONE:  sh_val = alu_val;
            SH_LEFT: begin
                sh_val  = {alu_val[DW-2:0], 1'b0};
                shout_o = alu_val[DW-1];
            end
            SH_RIGHT: begin
                sh_val  = {1'b0, alu_val[DW-1:1]};
                shout_o = alu_val[0];
            end
            SH_SWAP:  sh_val = {alu_val[HALF-1:0], alu_val[DW-1:HALF]};
            default:  sh_val = alu_val;
        endcase
    end

    assign result_o = mask_en_i ? (sh_val & mask_i) : sh_val;

endmodule

// File: rtl/reconf_datapath.sv
module reconf_datapath
    import dp_pkg::*;
#(
    parameter int DW         = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CFG_WORDS  = 8,
    localparam int SEQ_W     = $clog2(CFG_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEQ_W-1:0]     seq_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [HADDR_W-1:0]   host_addr,
    input  logic [DW-1:0]        host_wdata,
    output logic [DW-1:0]        host_rdata,
    output logic [DW-1:0]        alu_result,
    output logic                 carry_out,
    output logic                 shift_out,
    output logic                 cmp_eq0,
    output logic                 cmp_lt0,
    output logic                 cmp_eq1,
    output logic                 cmp_lt1,
    output logic                 a0_zero,
    output logic                 f0_full,
    output logic                 f0_empty,
    output logic                 f1_full,
    output logic                 f1_empty,
    output logic                 f0_overflow,
    output logic                 f0_underflow,
    output logic                 f1_overflow,
    output logic                 f1_underflow
);

    logic [DW-1:0] a0_q, a1_q, d0_q, d1_q, mask_q;
    ctl_t          ctl;
    logic [DW-1:0] op_a, op_b, res;
    logic          res_carry, res_shout;
    logic [DW-1:0] f0_head, f1_head, cfg_rd;
    logic          cfg_sel, cfg_wr;
    logic          f0_push, f0_pop, f1_push, f1_pop;
    logic [DW-1:0] f1_push_data;

    function automatic logic [DW-1:0] pick(input src_e s, input logic [DW-1:0] a0,
                                           input logic [DW-1:0] a1, input logic [DW-1:0] d0,
                                           input logic [DW-1:0] d1);
        unique case (s)
            SRC_A0:  return a0;
            SRC_A1:  return a1;
            SRC_D0:  return d0;
            default: return d1;
        endcase
    endfunction

    // ---- host decode ----
    assign cfg_sel = host_addr[HADDR_W-1];
    assign cfg_wr  = host_wr && cfg_sel;
    assign f0_push = host_wr && (host_addr == HA_F0);
    assign f0_pop  = (ctl.a0_wb == WB_FIFO) || (host_rd && host_addr == HA_F0);
    assign f1_push = ctl.push_f1 || (host_wr && host_addr == HA_F1);
    assign f1_push_data = ctl.push_f1 ? res : host_wdata;
    assign f1_pop  = (ctl.a1_wb == WB_FIFO) || (host_rd && host_addr == HA_F1);

    dp_cfg_store #(.WORDS(CFG_WORDS), .DW(DW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cfg_wr),
        .wr_idx_i   (host_addr[SEQ_W:1]),
        .wr_hi_i    (host_addr[0]),
        .wr_data_i  (host_wdata),
        .seq_idx_i  (seq_addr),
        .ctl_o      (ctl),
        .hrd_idx_i  (host_addr[SEQ_W:1]),
        .hrd_hi_i   (host_addr[0]),
        .hrd_data_o (cfg_rd)
    );

    // ---- operand selection and ALU ----
    assign op_a = pick(ctl.src_a, a0_q, a1_q, d0_q, d1_q);
    assign op_b = pick(ctl.src_b, a0_q, a1_q, d0_q, d1_q);

    dp_alu #(.DW(DW)) u_alu (
        .fn_i      (ctl.fn),
        .op_a_i    (op_a),
        .op_b_i    (op_b),
        .shift_i   (ctl.shift),
        .mask_en_i (ctl.mask_en),
        .mask_i    (mask_q),
        .result_o  (res),
        .carry_o   (res_carry),
        .shout_o   (res_shout)
    );

    // ---- FIFOs ----
    dp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_f0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (f0_push),
        .push_data_i (host_wdata),
        .pop_i       (f0_pop),
        .head_o      (f0_head),
        .full_o      (f0_full),
        .empty_o     (f0_empty),
        .overflow_o  (f0_overflow),
        .underflow_o (f0_underflow)
    );

    dp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_f1 (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (f1_push),
        .push_data_i (f1_push_data),
        .pop_i       (f1_pop),
        .head_o      (f1_head),
        .full_o      (f1_full),
        .empty_o     (f1_empty),
        .overflow_o  (f1_overflow),
        .underflow_o (f1_underflow)
    );

    // ---- accumulators: host write first, then control word ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a0_q <= '0;
        end else if (host_wr && host_addr == HA_A0) begin
            a0_q <= host_wdata;
        end else begin
            unique case (ctl.a0_wb)
                WB_HOLD: a0_q <= a0_q;
                WB_ALU:  a0_q <= res;
                WB_DATA: a0_q <= d0_q;
                WB_FIFO: a0_q <= f0_head;
                default: a0_q <= a0_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a1_q <= '0;
        end else if (host_wr && host_addr == HA_A1) begin
            a1_q <= host_wdata;
        end else begin
            unique case (ctl.a1_wb)
                WB_HOLD: a1_q <= a1_q;
                WB_ALU:  a1_q <= res;
                WB_DATA: a1_q <= d1_q;
                WB_FIFO: a1_q <= f1_head;
                default: a1_q <= a1_q;
            endcase
        end
    end

    // ---- host-only registers ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d0_q   <= '0;
            d1_q   <= '0;
            mask_q <= '1;
        end else if (host_wr) begin
            if (host_addr == HA_D0)   d0_q   <= host_wdata;
            if (host_addr == HA_D1)   d1_q   <= host_wdata;
            if (host_addr == HA_MASK) mask_q <= host_wdata;
        end
    end

    // ---- registered result and flags ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alu_result <= '0;
            carry_out  <= 1'b0;
            shift_out  <= 1'b0;
            cmp_eq0    <= 1'b0;
            cmp_lt0    <= 1'b0;
            cmp_eq1    <= 1'b0;
            cmp_lt1    <= 1'b0;
            a0_zero    <= 1'b0;
        end else begin
            alu_result <= res;
            carry_out  <= res_carry;
            shift_out  <= res_shout;
            cmp_eq0    <= (a0_q == d0_q);
            cmp_lt0    <= (a0_q <  d0_q);
            cmp_eq1    <= (a1_q == d1_q);
            cmp_lt1    <= (a1_q <  d1_q);
            a0_zero    <= (a0_q == '0);
        end
    end

    // ---- host read mux ----
    always_comb begin
        host_rdata = '0;
        if (cfg_sel) begin
            host_rdata = cfg_rd;
        end else begin
            unique case (host_addr)
                HA_A0:   host_rdata = a0_q;
                HA_A1:   host_rdata = a1_q;
                HA_D0:   host_rdata = d0_q;
                HA_D1:   host_rdata = d1_q;
                HA_F0:   host_rdata = f0_head;
                HA_F1:   host_rdata = f1_head;
                HA_MASK: host_rdata = mask_q;
                default: host_rdata = '0;
            endcase
        end
    end

    AST_CARRY_ONLY_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.fn != FN_ADD && ctl.fn != FN_SUB) |=> !carry_out);  // R3
    AST_SHIFT_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.shift == SH_NONE || ctl.shift == SH_SWAP) |=> !shift_out);  // R4
    AST_MASK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mask_en |=> ((alu_result & ~$past(mask_q)) == '0));  // R5
    AST_HOST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == HA_A0) |=> (a0_q == $past(host_wdata)));  // R9
    AST_CMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_eq0 && cmp_lt0) && !(cmp_eq1 && cmp_lt1));  // R13

endmodule

// File: tb/sim_reconf_datapath.sv
module sim_reconf_datapath;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] seq_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, alu_result;
    logic carry_out, shift_out, cmp_eq0, cmp_lt0, cmp_eq1, cmp_lt1, a0_zero;
    logic f0_full, f0_empty, f1_full, f1_empty;
    logic f0_overflow, f0_underflow, f1_overflow, f1_underflow;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    reconf_datapath u0 (
        .clk(clk), .rst_n(rst_n), .seq_addr(seq_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .alu_result(alu_result), .carry_out(carry_out), .shift_out(shift_out),
        .cmp_eq0(cmp_eq0), .cmp_lt0(cmp_lt0), .cmp_eq1(cmp_eq1), .cmp_lt1(cmp_lt1),
        .a0_zero(a0_zero), .f0_full(f0_full), .f0_empty(f0_empty),
        .f1_full(f1_full), .f1_empty(f1_empty),
        .f0_overflow(f0_overflow), .f0_underflow(f0_underflow),
        .f1_overflow(f1_overflow), .f1_underflow(f1_underflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cw(input int fn, input int sa, input int sb, input int sh,
                                       input int a0w, input int a1w, input bit push, input bit mk);
        return {1'b0, mk, push, 2'(a1w), 2'(a0w), 2'(sh), 2'(sb), 2'(sa), 3'(fn)};
    endfunction

    function automatic logic [7:0] sample_val(input int i);
        case (i)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; 3: return 8'h80;
            4: return 8'hFF; 5: return 8'h55; default: return 8'hA3;
        endcase
    endfunction

    task automatic hw(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic set_cfg(input int w, input logic [15:0] v);
        hw(5'(16 + 2*w), v[7:0]);
        hw(5'(17 + 2*w), v[15:8]);
    endtask

    task automatic run(input int w);
        @(negedge clk); seq_addr = 3'(w);
        @(negedge clk); seq_addr = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        host_addr = a; #1 v = host_rdata;
    endtask

    task automatic pop(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk); host_rd = 1'b1; host_addr = a; #1 v = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk("R14 result", alu_result, 0);
        chk("R14 carry", carry_out, 0);
        chk("R14 shout", shift_out, 0);
        chk("R14 empties", {f0_empty, f1_empty, f0_full, f1_full}, 4'b1100);
        chk("R14 sticky", {f0_overflow, f0_underflow, f1_overflow, f1_underflow}, 0);
        rd(5'h06, v); chk("R14 mask", v, 8'hFF);
        rd(5'h00, v); chk("R14 A0", v, 0);
        rd(5'h1F, v); chk("R14 cfg word7 hi", v, 0);
        run(3); chk("R8 zero word passes A0", alu_result, 0);

        // R1/R3 sweep of all ALU operations
        for (int fn = 0; fn < 8; fn++) begin
            set_cfg(1, cw(fn, 0, 3, 0, 0, 0, 0, 0));
            for (int i = 0; i < 7; i++) begin
                for (int j = 0; j < 7; j++) begin
                    int a, b, e, c;
                    a = sample_val(i); b = sample_val(j);
                    hw(5'h00, 8'(a)); hw(5'h03, 8'(b));
                    c = 0;
                    case (fn)
                        0: e = a;
                        1: e = a + 1;
                        2: e = a - 1;
                        3: begin e = a + b; c = (a + b > 255) ? 1 : 0; end
                        4: begin e = a - b; c = (a < b) ? 1 : 0; end
                        5: e = a & b;
                        6: e = a | b;
                        default: e = a ^ b;
                    endcase
                    run(1);
                    chk("R1 alu", alu_result, e & 255);
                    chk("R3 carry", carry_out, c);
                end
            end
        end

        // R4 shift sweep over all byte values
        for (int s = 0; s < 4; s++) begin
            set_cfg(2, cw(0, 1, 0, s, 0, 0, 0, 0));
            for (int a = 0; a < 256; a++) begin
                int e, so;
                hw(5'h01, 8'(a));
                so = 0;
                case (s)
                    0: e = a;
                    1: begin e = (a << 1) & 255; so = (a >> 7) & 1; end
                    2: begin e = a >> 1; so = a & 1; end
                    default: e = ((a & 15) << 4) | (a >> 4);
                endcase
                run(2);
                chk("R4 shift", alu_result, e);
                chk("R4 shout", shift_out, so);
            end
        end

        // R2 operand source selection
        hw(5'h00, 8'h01); hw(5'h01, 8'h02); hw(5'h02, 8'h04); hw(5'h03, 8'h08);
        for (int sa = 0; sa < 4; sa++) begin
            for (int sb = 0; sb < 4; sb++) begin
                set_cfg(1, cw(3, sa, sb, 0, 0, 0, 0, 0));
                run(1);
                chk("R2 sources", alu_result, (1 << sa) + (1 << sb));
            end
        end

        // R5 mask on and off
        hw(5'h06, 8'h3C); hw(5'h02, 8'hFF);
        set_cfg(3, cw(0, 2, 0, 0, 0, 0, 0, 1));
        set_cfg(4, cw(0, 2, 0, 0, 0, 0, 0, 0));
        run(3); chk("R5 masked", alu_result, 8'h3C);
        run(4); chk("R5 unmasked", alu_result, 8'hFF);
        hw(5'h06, 8'hFF);

        // R6 write-back codes
        hw(5'h00, 8'h42);
        set_cfg(1, cw(1, 0, 0, 0, 0, 0, 0, 0));
        run(1); rd(5'h00, v); chk("R6 hold", v, 8'h42);
        hw(5'h00, 8'h03); hw(5'h02, 8'h05);
        set_cfg(2, cw(3, 0, 2, 0, 1, 0, 0, 0));
        run(2); rd(5'h00, v); chk("R6 A0 from ALU", v, 8'h08);
        hw(5'h03, 8'h77);
        set_cfg(2, cw(0, 0, 0, 0, 0, 2, 0, 0));
        run(2); rd(5'h01, v); chk("R6 A1 from D1", v, 8'h77);
        hw(5'h04, 8'h9A);
        set_cfg(2, cw(0, 0, 0, 0, 3, 0, 0, 0));
        run(2); rd(5'h00, v); chk("R6 A0 from F0", v, 8'h9A);
        chk("R6 F0 popped", f0_empty, 1);
        run(2); rd(5'h00, v); chk("R12 A0 from empty F0", v, 0);
        chk("R12 F0 underflow", f0_underflow, 1);
        hw(5'h05, 8'h3C);
        set_cfg(2, cw(0, 0, 0, 0, 0, 3, 0, 0));
        run(2); rd(5'h01, v); chk("R6 A1 from F1", v, 8'h3C);

        // R7 push result to F1
        hw(5'h02, 8'hC5);
        set_cfg(3, cw(0, 2, 0, 0, 0, 0, 1, 0));
        run(3); chk("R7 F1 nonempty", f1_empty, 0);
        pop(5'h05, v); chk("R7 pushed value", v, 8'hC5);
        chk("R7 F1 empty after pop", f1_empty, 1);

        // R9 host write wins
        set_cfg(2, cw(1, 0, 0, 0, 1, 0, 0, 0));
        @(negedge clk); seq_addr = 3'd2; host_wr = 1'b1; host_addr = 5'h00; host_wdata = 8'h11;
        @(negedge clk); seq_addr = '0; host_wr = 1'b0;
        rd(5'h00, v); chk("R9 host priority", v, 8'h11);
        hw(5'h03, 8'h5E); rd(5'h03, v); chk("R9 D1 readback", v, 8'h5E);

        // R8 per-cycle word selection and readback
        set_cfg(7, cw(1, 0, 0, 0, 0, 0, 0, 0));
        hw(5'h00, 8'h20);
        run(7); chk("R8 word 7", alu_result, 8'h21);
        run(0); chk("R8 word 0", alu_result, 8'h20);
        rd(5'h1E, v); chk("R8 cfg low readback", v, 8'h01);

        // R10/R11 FIFO order and overflow
        for (int k = 1; k <= 4; k++) hw(5'h04, 8'(k * 16));
        chk("R10 F0 full", f0_full, 1);
        chk("R11 no overflow yet", f0_overflow, 0);
        hw(5'h04, 8'h50);
        chk("R11 overflow sticky", f0_overflow, 1);
        for (int k = 1; k <= 4; k++) begin
            pop(5'h04, v); chk("R10 F0 order", v, k * 16);
        end
        chk("R11 dropped byte absent", f0_empty, 1);
        // R12 host pop from empty
        pop(5'h05, v); chk("R12 empty pop data", v, 0);
        chk("R12 F1 underflow", f1_underflow, 1);

        // R13 compare sweep
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                int x, y;
                x = sample_val(i); y = sample_val(j);
                hw(5'h00, 8'(x)); hw(5'h02, 8'(y)); hw(5'h01, 8'(y)); hw(5'h03, 8'(x));
                @(negedge clk);
                chk("R13 compares", {cmp_eq0, cmp_lt0, cmp_eq1, cmp_lt1, a0_zero},
                    {x == y, x < y, y == x, y < x, x == 0});
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule